// File: doc/BRIEF.md
# Self-Timed Word Write Sequencer

This block runs the internal write cycle of a small serial word memory. Once the command front end has taken in a complete write command, it raises a one-cycle request carrying the target address and the 16-bit word. After a short fixed delay, the sequencer opens a busy window. It first erases the addressed word to all ones, then programs the new value. At the end of the window it releases the busy indication by itself. The length of the window is a count of system clocks. That count is split into an erase phase and a program phase, both set by parameters.

A write-control input can stop the cycle. If it rises before the busy window opens, the write is dropped and the word is left as it was. If it rises during the window, the write stops at once and the addressed word is loaded with a fixed corruption marker. This marks the result as undefined.

The ready/busy level is always driven on its own pin. It can also be routed onto the serial data output: after a write, lower the active-low chip select while the serial clock is low. Once the window has ended, a rising chip select returns the sequencer to its idle state, where it waits for the next command.

Top module: `write_cycle_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `mem_we` is 0 and `dout_oe` is 0.
- R2: A `wr_req` accepted in the idle state makes `ready` drop to 0 on exactly the SETUP_CYC-th rising clock edge after the edge that sampled the request.
- R3: `ready` stays 0 for exactly ERASE_CYC+PROG_CYC clocks and then returns to 1 with no input activity.
- R4: On the edge where `ready` falls, the block writes all ones (`mem_wdata` all bits 1) to the latched address. ERASE_CYC clocks later it writes the requested word there, so a completed cycle makes exactly two writes.
- R5: A `wr_req` that arrives while a cycle is busy is ignored: it causes no write and does not change the current cycle.
- R6: Toggling `sel_n` (1 = deselected) during the busy window does not change the result or the number of writes.
- R7: `wc` = 1 while the request is still in its setup delay cancels the cycle regardless of `sel_n`: no write occurs, `ready` never drops, and the block accepts the next request.
- R8: `wc` = 1 sampled during the busy window ends it on that edge: `ready` is 1 after the edge, and a write of CORRUPT (default 16'hDEAD) to the latched address is issued at the same edge.
- R9: If `sel_n` falls while `sclk_lvl` is 0 after a request has been accepted, `dout_oe` is 1 and `dout` equals `ready` from the next clock on, until `sel_n` is seen high. A fall of `sel_n` while `sclk_lvl` is 1 does not enter this status mode.
- R10: After the window ends with `sel_n` held low, the block ignores new requests until `sel_n` has been sampled high once.
- R11: Outside status mode, `dout` and `dout_oe` follow `cmd_do` and `cmd_do_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | One-cycle write request from the command front end |
| wr_addr | input | ADDR_W | Word address of the request |
| wr_data | input | DATA_W | Word to be written |
| wc | input | 1 | Write-control, 1 aborts a pending or running write |
| sel_n | input | 1 | Chip select, active low |
| sclk_lvl | input | 1 | Synchronised level of the serial clock |
| cmd_do | input | 1 | Serial output bit from the command front end |
| cmd_do_oe | input | 1 | Output enable from the command front end |
| ready | output | 1 | 1 = ready for a command, 0 = write window in progress |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Serial output enable |
| mem_we | output | 1 | Array write strobe, one cycle |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The assertions assume that reset is held for several clocks before the first request. They also assume that `wr_req` is a single-cycle pulse and that `cmd_do_oe` stays low whenever status mode is expected to own the output. The stimulus changes all inputs only on falling clock edges and keeps `cmd_do_oe` low except in the pass-through check. It raises `wc` only for one cycle, at a chosen phase of the cycle. The sweeps cover every address of a 4-bit configuration and abort points in setup, erase and program.

// File: rtl/wcc_pkg.sv
// Shared types for the self-timed write sequencer.
package wcc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for a request
        PH_SETUP,  // fixed delay before the busy window
        PH_ERASE,  // word forced to all ones
        PH_PROG,   // word loaded with the new value
        PH_DONE    // window over, waiting for deselect
    } phase_t;
endpackage

// File: rtl/wcc_timer.sv
// Down-counter for phase lengths.
// Assumes: load_val is the phase length minus one; zero marks the last cycle.
module wcc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    assign zero = (cnt_q == '0);

    // Load a new phase length or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (!zero)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/wcc_sequencer.sv
// Phase sequencer: setup delay, erase, program, done.
// It issues one-cycle array writes at phase boundaries and on abort.
// Assumes: wr_req is a single-cycle pulse; wc is synchronous to clk.
module wcc_sequencer
    import wcc_pkg::*;
#(
    parameter int                ADDR_W    = 9,
    parameter int                DATA_W    = 16,
    parameter int                SETUP_CYC = 4,
    parameter int                ERASE_CYC = 8,
    parameter int                PROG_CYC  = 8,
    parameter logic [DATA_W-1:0] CORRUPT   = 16'hDEAD,
    parameter int                CNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wc,
    input  logic              sel_n,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              ready,
    output logic              seq_active,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);

    phase_t            phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;

    // Select the timer reload on each phase change.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_IDLE:  if (wr_req)             begin tmr_load = 1'b1; tmr_val = SETUP_LD; end
            PH_SETUP: if (!wc && tmr_zero)    begin tmr_load = 1'b1; tmr_val = ERASE_LD; end
            PH_ERASE: if (!wc && tmr_zero)    begin tmr_load = 1'b1; tmr_val = PROG_LD;  end
            default:  ;
        endcase
    end

    // Advance phases, latch the request and issue array writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else begin
            we_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (wr_req) begin
                        addr_q  <= wr_addr;
                        data_q  <= wr_data;
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (wc) begin
                        phase_q <= PH_IDLE;
                    end else if (tmr_zero) begin
                        phase_q <= PH_ERASE;
                        we_q    <= 1'b1;
                        wdata_q <= '1;
                    end
                end
                PH_ERASE: begin
                    if (wc) begin
                        phase_q <= PH_IDLE;
                        we_q    <= 1'b1;
                        wdata_q <= CORRUPT;
                    end else if (tmr_zero) begin
                        phase_q <= PH_PROG;
                        we_q    <= 1'b1;
                        wdata_q <= data_q;
                    end
                end
                PH_PROG: begin
                    if (wc) begin
                        phase_q <= PH_IDLE;
                        we_q    <= 1'b1;
                        wdata_q <= CORRUPT;
                    end else if (tmr_zero) begin
                        phase_q <= PH_DONE;
                    end
                end
                PH_DONE: begin
                    if (sel_n)
                        phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign ready      = !((phase_q == PH_ERASE) || (phase_q == PH_PROG));
    assign seq_active = (phase_q != PH_IDLE);
    assign mem_we     = we_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
endmodule

// File: rtl/wcc_status_mux.sv
// Routes ready/busy onto the serial output after a select fall with the clock low.
// Assumes: sel_n and sclk_lvl are already synchronised to clk.
module wcc_status_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic sclk_lvl,
    input  logic seq_active,
    input  logic ready,
    input  logic cmd_do,
    input  logic cmd_do_oe,
    output logic dout,
    output logic dout_oe
);
    logic sel_q;
    logic status_q;

    // Track select and enter or leave status mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b1;
            status_q <= 1'b0;
        end else begin
            sel_q <= sel_n;
            if (sel_n)
                status_q <= 1'b0;
            else if (sel_q && !sclk_lvl && seq_active)
                status_q <= 1'b1;
        end
    end

    assign dout    = status_q ? ready : cmd_do;
    assign dout_oe = status_q | cmd_do_oe;
endmodule

// File: rtl/write_cycle_ctrl.sv
// Top of the self-timed write sequencer: timer, phase sequencer, status mux.
// Assumes: all inputs synchronous to clk; wr_req comes as a one-cycle pulse.
module write_cycle_ctrl
    import wcc_pkg::*;
#(
    parameter int                ADDR_W    = 9,
    parameter int                DATA_W    = 16,
    parameter int                SETUP_CYC = 4,
    parameter int                ERASE_CYC = 250000,
    parameter int                PROG_CYC  = 250000,
    parameter logic [DATA_W-1:0] CORRUPT   = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wc,
    input  logic              sel_n,
    input  logic              sclk_lvl,
    input  logic              cmd_do,
    input  logic              cmd_do_oe,
    output logic              ready,
    output logic              dout,
    output logic              dout_oe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int MAX_EP = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAX_C  = (MAX_EP > SETUP_CYC) ? MAX_EP : SETUP_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             seq_active;

    wcc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    wcc_sequencer #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC),
        .CORRUPT   (CORRUPT),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wc         (wc),
        .sel_n      (sel_n),
        .tmr_zero   (tmr_zero),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .ready      (ready),
        .seq_active (seq_active),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    wcc_status_mux u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .sclk_lvl   (sclk_lvl),
        .seq_active (seq_active),
        .ready      (ready),
        .cmd_do     (cmd_do),
        .cmd_do_oe  (cmd_do_oe),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );
endmodule

// File: rtl/write_cycle_ctrl_chk.sv
// Port-level property checker for the write sequencer, attached by bind.
// Assumes: reset held for at least two clocks before use.
module write_cycle_ctrl_chk #(
    parameter int                DATA_W   = 16,
    parameter int                BUSY_MAX = 16,
    parameter logic [DATA_W-1:0] CORRUPT  = 16'hDEAD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wc,
    input logic              sel_n,
    input logic              cmd_do_oe,
    input logic              ready,
    input logic              dout,
    input logic              dout_oe,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);
    logic [31:0] busy_run;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy_run <= '0;
        else if (ready) busy_run <= '0;
        else            busy_run <= busy_run + 1'b1;
    end

    assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 32'(BUSY_MAX));

    assert_erase_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> (mem_we && (mem_wdata == '1)));

    assert_abort_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wc) |=> ready);

    assert_abort_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wc) |=> (mem_we && (mem_wdata == CORRUPT)));

    assert_status_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && !cmd_do_oe) |-> (dout == ready));

    assert_status_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (dout_oe == cmd_do_oe));
endmodule

bind write_cycle_ctrl write_cycle_ctrl_chk #(
    .DATA_W   (DATA_W),
    .BUSY_MAX (ERASE_CYC + PROG_CYC),
    .CORRUPT  (CORRUPT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wc        (wc),
    .sel_n     (sel_n),
    .cmd_do_oe (cmd_do_oe),
    .ready     (ready),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/sim_write_cycle_ctrl.sv
// Bench: sweeps every address of a 4-bit configuration and each abort point.
module sim_write_cycle_ctrl;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int SETUP = 3;
    localparam int ERASE = 8;
    localparam int PROG  = 12;
    localparam logic [DW-1:0] MARK = 16'hDEAD;

    logic clk = 1'b0;
    logic rst_n, wr_req, wc, sel_n, sclk_lvl, cmd_do, cmd_do_oe;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic ready, dout, dout_oe, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] bmem [1<<AW];
    int we_cnt;

    always #10 clk = ~clk;

    write_cycle_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP),
        .ERASE_CYC(ERASE), .PROG_CYC(PROG), .CORRUPT(MARK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wc(wc), .sel_n(sel_n), .sclk_lvl(sclk_lvl),
        .cmd_do(cmd_do), .cmd_do_oe(cmd_do_oe), .ready(ready), .dout(dout),
        .dout_oe(dout_oe), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    // Bench model of the array, written from the block's write port.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1<<AW); i++) bmem[i] <= '0;
            we_cnt <= 0;
        end else if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 16'h1357) ^ 16'h0F0F;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_req(input int a, input logic [DW-1:0] d);
        wr_req = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic wait_low();
        for (int k = 0; k < 100 && ready; k++) @(negedge clk);
    endtask

    task automatic wait_high();
        for (int k = 0; k < 300 && !ready; k++) @(negedge clk);
    endtask

    task automatic full_write(input int a, input logic [DW-1:0] d);
        int lat, busy, w0;
        logic [DW-1:0] saw;
        w0 = we_cnt;
        saw = '0;
        start_req(a, d);
        lat = 0;
        while (ready && lat < 100) begin @(negedge clk); lat++; end
        busy = 0;
        while (!ready && busy < 300) begin
            @(negedge clk); busy++;
            if (busy == 1) saw = bmem[a];
        end
        @(negedge clk);
        chk("R2 setup delay", lat, SETUP);
        chk("R3 busy length", busy, ERASE + PROG);
        chk("R4 erase value", saw, 16'hFFFF);
        chk("R4 final word", bmem[a], d);
        chk("R4 write count", we_cnt - w0, 2);
    endtask

    initial begin
        int w0, lowseen;
        rst_n = 1'b0; wr_req = 1'b0; wc = 1'b0; sel_n = 1'b1; sclk_lvl = 1'b0;
        cmd_do = 1'b0; cmd_do_oe = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", ready, 1);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 dout_oe", dout_oe, 0);

        // Sweep all addresses.
        for (int a = 0; a < (1<<AW); a++) full_write(a, pat(a));
        for (int a = 0; a < (1<<AW); a++) chk("R4 sweep contents", bmem[a], pat(a));

        // R5: request during busy ignored.
        w0 = we_cnt;
        start_req(2, 16'h1234);
        repeat (6) @(negedge clk);
        start_req(5, 16'hFFFF);
        repeat (40) @(negedge clk);
        chk("R5 other word untouched", bmem[5], pat(5));
        chk("R5 target written", bmem[2], 16'h1234);
        chk("R5 write count", we_cnt - w0, 2);

        // R6: toggling select during busy.
        w0 = we_cnt;
        sclk_lvl = 1'b1;
        start_req(3, 16'hBEEF);
        for (int k = 0; k < 40; k++) begin sel_n = ~sel_n; @(negedge clk); end
        sel_n = 1'b1; sclk_lvl = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 word", bmem[3], 16'hBEEF);
        chk("R6 write count", we_cnt - w0, 2);

        // R7: abort during setup, select high.
        w0 = we_cnt; lowseen = 0;
        start_req(4, 16'h0001);
        wc = 1'b1;
        @(negedge clk);
        wc = 1'b0;
        for (int k = 0; k < 40; k++) begin if (!ready) lowseen = 1; @(negedge clk); end
        chk("R7 ready never low", lowseen, 0);
        chk("R7 no write", we_cnt - w0, 0);
        chk("R7 word unchanged", bmem[4], pat(4));
        full_write(4, 16'h4444);

        // R8: abort during erase.
        w0 = we_cnt;
        start_req(6, 16'h6666);
        wait_low();
        repeat (2) @(negedge clk);
        wc = 1'b1;
        @(negedge clk);
        chk("R8 ready after erase abort", ready, 1);
        wc = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 erase abort marker", bmem[6], MARK);
        chk("R8 erase abort writes", we_cnt - w0, 2);
        chk("R8 stays ready", ready, 1);

        // R8: abort during program.
        w0 = we_cnt;
        start_req(7, 16'h7777);
        wait_low();
        repeat (ERASE + 3) @(negedge clk);
        wc = 1'b1;
        @(negedge clk);
        chk("R8 ready after program abort", ready, 1);
        wc = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 program abort marker", bmem[7], MARK);
        chk("R8 program abort writes", we_cnt - w0, 3);
        full_write(7, 16'h7007);

        // R9: status on the serial output.
        start_req(10, 16'hAAAA);
        wait_low();
        sel_n = 1'b0; sclk_lvl = 1'b0;
        @(negedge clk);
        chk("R9 status oe busy", dout_oe, 1);
        chk("R9 status value busy", dout, 0);
        wait_high();
        @(negedge clk);
        chk("R9 status oe ready", dout_oe, 1);
        chk("R9 status value ready", dout, 1);
        sel_n = 1'b1;
        @(negedge clk);
        chk("R9 status released", dout_oe, 0);
        start_req(11, 16'hBBBB);
        wait_low();
        sclk_lvl = 1'b1; sel_n = 1'b0;
        @(negedge clk);
        chk("R9 no status with clock high", dout_oe, 0);
        wait_high();
        sel_n = 1'b1; sclk_lvl = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 word after status poll", bmem[10], 16'hAAAA);

        // R10: done state waits for deselect.
        sclk_lvl = 1'b1; sel_n = 1'b0;
        start_req(8, 16'h8888);
        wait_low();
        wait_high();
        repeat (2) @(negedge clk);
        w0 = we_cnt;
        start_req(9, 16'h9999);
        repeat (30) @(negedge clk);
        chk("R10 request ignored writes", we_cnt - w0, 0);
        chk("R10 request ignored word", bmem[9], pat(9));
        sel_n = 1'b1; sclk_lvl = 1'b0;
        @(negedge clk);
        full_write(9, 16'h9999);

        // R11: pass-through outside status mode.
        cmd_do_oe = 1'b1; cmd_do = 1'b1; #1;
        chk("R11 oe pass", dout_oe, 1);
        chk("R11 data one", dout, 1);
        cmd_do = 1'b0; #1;
        chk("R11 data zero", dout, 0);
        cmd_do_oe = 1'b0; #1;
        chk("R11 oe off", dout_oe, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule